// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs a single NAND bus transaction, described by one command word written from the host side. Each bit of the word turns a phase on or off. The phases are a first command latch, a run of address cycles, a programmed-I/O data transfer of one to four bytes, a second command latch, and a wait for the ready/busy line. The second command normally comes right after the address phase. One flag moves it to after the data phase, which gives the order that a page program needs.

Opcodes come from two byte-wide command registers. Address bytes come from two 32-bit address registers. Data moves through one 32-bit response register: it is the byte source when transmitting and the capture target when receiving. The block drives the chip enables, the command and address latch enables, the write and read strobes and the 8-bit I/O bus. A small timing engine gives every bus cycle a fixed low time and high time. When the transaction ends, the block emits a one-cycle done pulse, clears the start bit and sets a sticky interrupt flag.

Host writes go through a simple port. `hostAddr` selects the target:

| hostAddr | Target |
|---|---|
| 0 | Command word |
| 1 | Command register 1 |
| 2 | Command register 2 |
| 3 | Address register, low word |
| 4 | Address register, high word |
| 5 | Response register |
| 6 | Interrupt clear |

Top module: `nand_cmd_seq`

## Requirements
- R1: Writing the command word (hostAddr 0) with bit 31 set, while the block is idle, starts a transaction. When the transaction ends, `donePulse` is high for exactly one cycle, and from the next cycle on bit 31 of `cmdWord` reads 0.
- R2: Bit 30 enables a command-latch cycle (`cle`=1) that drives command register 1 (hostAddr 1). Bit 25 enables a second command-latch cycle that drives command register 2 (hostAddr 2).
- R3: Bit 29 enables the address phase, which runs bits 3:0 plus one cycles with `ale`=1. Byte k, least significant first, comes from the low address word (hostAddr 3) for k=0..3 and from the high word (hostAddr 4) for k=4..7. Cycles 8 to 15 drive 0x00.
- R4: When bits 28 (PIO) and 27 (transmit) are set, the data phase sends the response register bytes, least significant first, on `weN` strobes with `cle`=`ale`=0. The byte count is bits 23:20 plus one, clamped to 4.
- R5: When bits 28 and 26 (receive) are set and bit 27 is clear, the data phase pulses `reN` once per byte. It stores each byte sampled on `ioIn` into response register lane k, in order. Starting such a transaction clears the response register first. If bits 27 and 26 are both set, the block transmits.
- R6: Phases run in a fixed order: first command, address, second command (when bit 24 is 0), wait, data, second command (when bit 24 is 1). Disabled phases are skipped.
- R7: Bit 16 holds the sequencer after the command and address phases, with no strobe, until `rbReady` is 1. Only then does data move.
- R8: For the whole transaction, `ceN` is the inverse of command word bits 15:8, which must be one-hot. While idle, every `ceN` line is high.
- R9: Writing an all-zero command word aborts a running transaction. From the next cycle on, the block is idle, every `ceN` line is high and `cmdWord` is 0. No done pulse follows.
- R10: A done pulse sets `doneIrq`, which stays set until a write to hostAddr 6 with bit 0 set clears it. If that write falls in the same cycle as the done pulse, the set wins.
- R11: While a transaction runs, any nonzero write to the command word is ignored. `cmdWord` and the bus sequence do not change.
- R12: Each bus cycle holds its strobe low for LOW_CYC clocks (default 2), then high for HIGH_CYC clocks. `weN` and `reN` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 3 | Host register select |
| hostWData | input | 32 | Host write data |
| cmdWord | output | 32 | Current command word |
| respData | output | 32 | Response register |
| doneIrq | output | 1 | Sticky command-done flag |
| donePulse | output | 1 | One-cycle completion pulse |
| ceN | output | NUM_CE | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Active-low write strobe |
| reN | output | 1 | Active-low read strobe |
| ioOut | output | 8 | Bus output byte |
| ioOe | output | 1 | Bus output enable |
| ioIn | input | 8 | Bus input byte |
| rbReady | input | 1 | Ready/busy line, 1 = ready |

## Verification
The completion pulse, which sets the interrupt flag, can land in the same cycle as a host write that clears that flag. The bench provokes this collision by watching `donePulse` mid-cycle and driving the clear write at once, so both act on the same edge. The check passes only if `doneIrq` reads 1 afterwards. An abort write can also land during the ready wait. There the bench expects an immediate return to idle, with no completion pulse and no interrupt.

// File: rtl/nfc_seq_pkg.sv
package nfc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD1  = 3'd1,
    PH_ADDR  = 3'd2,
    PH_CMD2E = 3'd3,
    PH_WAIT  = 3'd4,
    PH_DATA  = 3'd5,
    PH_CMD2L = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    SRC_CMD1 = 2'd0,
    SRC_CMD2 = 2'd1,
    SRC_ADDR = 2'd2,
    SRC_DATA = 2'd3
  } busSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    idle;
    logic    finish;
    logic    rxCapture;
    busSrc_e src;
    logic [3:0] idx;
  } dpCtl_t;

  // decoded command word fields used by control
  typedef struct packed {
    logic       go;
    logic       cmd1En;
    logic       addrEn;
    logic       pio;
    logic       tx;
    logic       rx;
    logic       sec;
    logic       aft;
    logic [3:0] tsz;
    logic       waitEn;
    logic [3:0] alen;
  } cmdFields_t;

  localparam int B_GO   = 31;
  localparam int B_CMD1 = 30;
  localparam int B_ADDR = 29;
  localparam int B_PIO  = 28;
  localparam int B_TX   = 27;
  localparam int B_RX   = 26;
  localparam int B_SEC  = 25;
  localparam int B_AFT  = 24;
  localparam int B_TSZ  = 20;
  localparam int B_WAIT = 16;
  localparam int B_CE   = 8;
  localparam int B_ALEN = 0;

  localparam logic [2:0] HA_CMD  = 3'd0;
  localparam logic [2:0] HA_OP1  = 3'd1;
  localparam logic [2:0] HA_OP2  = 3'd2;
  localparam logic [2:0] HA_ADLO = 3'd3;
  localparam logic [2:0] HA_ADHI = 3'd4;
  localparam logic [2:0] HA_RESP = 3'd5;
  localparam logic [2:0] HA_IRQ  = 3'd6;

endpackage

// File: rtl/nfc_seq_timing.sv
module nfc_seq_timing #(
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycReq,
  output logic strobeLow,
  output logic sampleEn,
  output logic cycDone
);
  localparam int LEN = LOW_CYC + HIGH_CYC;
  localparam int CW  = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST   = CW'(LEN - 1);
  localparam logic [CW-1:0] LOWEND = CW'(LOW_CYC);
  localparam logic [CW-1:0] SAMPLE = CW'(LOW_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!cycReq || cycDone) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign strobeLow = cycReq && (cnt < LOWEND);
  assign sampleEn  = cycReq && (cnt == SAMPLE);
  assign cycDone   = cycReq && (cnt == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R12

endmodule

// File: rtl/nfc_seq_ctrl.sv
module nfc_seq_ctrl
  import nfc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cmdFields_t fld,
  input  logic       abortReq,
  input  logic       rbReady,
  input  logic       cycDone,
  input  logic       sampleEn,
  output dpCtl_t     ctl,
  output phase_e     phase,
  output logic       cycReq,
  output logic       dataRx
);

  logic [3:0] idx;
  logic [3:0] lastIdx;
  logic [7:0] enVec;
  logic       dataEn;

  assign dataEn = fld.pio && (fld.tx || fld.rx);
  assign dataRx = fld.rx && !fld.tx;
  assign enVec  = {1'b1, fld.sec && fld.aft, dataEn, fld.waitEn,
                   fld.sec && !fld.aft, fld.addrEn, fld.cmd1En, 1'b0};

  function automatic phase_e pickNext(input logic [2:0] cur, input logic [7:0] en);
    phase_e r;
    logic   hit;
    r   = PH_DONE;
    hit = 1'b0;
    for (int i = 1; i < 8; i++) begin
      if (!hit && (i > int'(cur)) && en[i]) begin
        r   = phase_e'(3'(i));
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    case (phase)
      PH_ADDR: lastIdx = fld.alen;
      PH_DATA: lastIdx = (fld.tsz > 4'd3) ? 4'd3 : fld.tsz;
      default: lastIdx = 4'd0;
    endcase
  end

  assign cycReq = (phase == PH_CMD1) || (phase == PH_ADDR) || (phase == PH_CMD2E) ||
                  (phase == PH_DATA) || (phase == PH_CMD2L);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else if (abortReq) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          idx <= '0;
          if (fld.go) phase <= pickNext(3'd0, enVec);
        end
        PH_WAIT: begin
          if (rbReady) phase <= pickNext(phase, enVec);
        end
        PH_DONE: phase <= PH_IDLE;
        default: begin
          if (cycDone) begin
            if (idx == lastIdx) begin
              idx   <= '0;
              phase <= pickNext(phase, enVec);
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.idle      = (phase == PH_IDLE);
    ctl.finish    = (phase == PH_DONE);
    ctl.rxCapture = (phase == PH_DATA) && dataRx && sampleEn;
    ctl.idx       = idx;
    case (phase)
      PH_CMD1:  ctl.src = SRC_CMD1;
      PH_ADDR:  ctl.src = SRC_ADDR;
      PH_DATA:  ctl.src = SRC_DATA;
      default:  ctl.src = SRC_CMD2;
    endcase
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && !rbReady && !abortReq) |=> (phase == PH_WAIT)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (phase == PH_IDLE)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |=> (phase == PH_IDLE)); // R1

endmodule

// File: rtl/nfc_seq_datapath.sv
module nfc_seq_datapath
  import nfc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic [2:0]  hostAddr,
  input  logic [31:0] hostWData,
  input  dpCtl_t      ctl,
  input  logic [7:0]  ioIn,
  output logic        abortReq,
  output logic [31:0] cmdWord,
  output logic [31:0] respData,
  output logic        doneIrq,
  output logic [7:0]  busByte
);

  logic [7:0]  op1Reg, op2Reg;
  logic [31:0] adLo, adHi;
  logic        wrCmd, acceptCmd, clearResp;

  assign wrCmd     = hostWr && (hostAddr == HA_CMD);
  assign abortReq  = wrCmd && (hostWData == 32'd0);
  assign acceptCmd = wrCmd && ctl.idle && (hostWData != 32'd0);
  assign clearResp = acceptCmd && hostWData[B_GO] && hostWData[B_PIO] &&
                     hostWData[B_RX] && !hostWData[B_TX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdWord <= '0;
    else if (abortReq) cmdWord <= '0;
    else if (acceptCmd) cmdWord <= hostWData;
    else if (ctl.finish) cmdWord[B_GO] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Reg <= '0;
      op2Reg <= '0;
      adLo   <= '0;
      adHi   <= '0;
    end else if (hostWr) begin
      case (hostAddr)
        HA_OP1:  op1Reg <= hostWData[7:0];
        HA_OP2:  op2Reg <= hostWData[7:0];
        HA_ADLO: adLo   <= hostWData;
        HA_ADHI: adHi   <= hostWData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respData <= '0;
    else if (ctl.rxCapture) respData[ctl.idx[1:0]*8 +: 8] <= ioIn;
    else if (clearResp) respData <= '0;
    else if (hostWr && hostAddr == HA_RESP) respData <= hostWData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneIrq <= 1'b0;
    else if (ctl.finish) doneIrq <= 1'b1;
    else if (hostWr && hostAddr == HA_IRQ && hostWData[0]) doneIrq <= 1'b0;
  end

  always_comb begin
    case (ctl.src)
      SRC_CMD1: busByte = op1Reg;
      SRC_CMD2: busByte = op2Reg;
      SRC_DATA: busByte = respData[ctl.idx[1:0]*8 +: 8];
      default: begin
        if (ctl.idx < 4'd4)      busByte = adLo[ctl.idx[1:0]*8 +: 8];
        else if (ctl.idx < 4'd8) busByte = adHi[ctl.idx[1:0]*8 +: 8];
        else                     busByte = 8'h00;
      end
    endcase
  end

  AST_FINISH_CLEARS_GO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !hostWr) |=> !cmdWord[B_GO]); // R1
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> doneIrq); // R10
  AST_BUSY_WORD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.idle && !ctl.finish && !abortReq) |=> $stable(cmdWord)); // R11

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nfc_seq_pkg::*;
#(
  parameter int NUM_CE   = 8,
  parameter int LOW_CYC  = 2,
  parameter int HIGH_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [31:0]       hostWData,
  output logic [31:0]       cmdWord,
  output logic [31:0]       respData,
  output logic              doneIrq,
  output logic              donePulse,
  output logic [NUM_CE-1:0] ceN,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [7:0]        ioOut,
  output logic              ioOe,
  input  logic [7:0]        ioIn,
  input  logic              rbReady
);

  dpCtl_t     ctl;
  cmdFields_t fld;
  phase_e     phase;
  logic       abortReq, cycReq, strobeLow, sampleEn, cycDone, dataRx;
  logic       busy, txPhase, rxPhase;

  assign fld.go     = cmdWord[B_GO];
  assign fld.cmd1En = cmdWord[B_CMD1];
  assign fld.addrEn = cmdWord[B_ADDR];
  assign fld.pio    = cmdWord[B_PIO];
  assign fld.tx     = cmdWord[B_TX];
  assign fld.rx     = cmdWord[B_RX];
  assign fld.sec    = cmdWord[B_SEC];
  assign fld.aft    = cmdWord[B_AFT];
  assign fld.tsz    = cmdWord[B_TSZ +: 4];
  assign fld.waitEn = cmdWord[B_WAIT];
  assign fld.alen   = cmdWord[B_ALEN +: 4];

  nfc_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWData(hostWData), .ctl(ctl), .ioIn(ioIn), .abortReq(abortReq),
    .cmdWord(cmdWord), .respData(respData), .doneIrq(doneIrq), .busByte(ioOut)
  );

  nfc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fld(fld), .abortReq(abortReq), .rbReady(rbReady),
    .cycDone(cycDone), .sampleEn(sampleEn), .ctl(ctl), .phase(phase),
    .cycReq(cycReq), .dataRx(dataRx)
  );

  nfc_seq_timing #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_tim (
    .clk(clk), .rstN(rstN), .cycReq(cycReq), .strobeLow(strobeLow),
    .sampleEn(sampleEn), .cycDone(cycDone)
  );

  assign busy      = (phase != PH_IDLE);
  assign donePulse = ctl.finish;
  assign cle       = (phase == PH_CMD1) || (phase == PH_CMD2E) || (phase == PH_CMD2L);
  assign ale       = (phase == PH_ADDR);
  assign rxPhase   = (phase == PH_DATA) && dataRx;
  assign txPhase   = cle || ale || ((phase == PH_DATA) && !dataRx);
  assign weN       = !(strobeLow && txPhase);
  assign reN       = !(strobeLow && rxPhase);
  assign ioOe      = txPhase;
  assign ceN       = busy ? ~cmdWord[B_CE +: NUM_CE] : '1;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN)); // R12
  AST_ABORT_CE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (&ceN)); // R9

endmodule

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [31:0] hostWData = '0;
  logic [31:0] cmdWord, respData;
  logic        doneIrq, donePulse, cle, ale, weN, reN, ioOe;
  logic [7:0]  ceN, ioOut;
  logic [7:0]  ioIn = 8'h00;
  logic        rbReady = 1'b1;

  always #5 clk = ~clk;

  nand_cmd_seq dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWData(hostWData), .cmdWord(cmdWord), .respData(respData),
    .doneIrq(doneIrq), .donePulse(donePulse), .ceN(ceN), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rbReady(rbReady)
  );

  int vecs = 0;
  int errs = 0;
  int rdCount = 0;
  int weLow = 0;
  logic prevWe = 1'b1, prevRe = 1'b1;
  logic [7:0] expCe = 8'hFF;
  logic [9:0] expQ[$];
  logic [7:0] rxQ[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWData = d;
    @(negedge clk);
    hostWr = 1'b0; hostWData = '0;
  endtask

  task automatic pushExp(input logic c, input logic a, input logic [7:0] b);
    expQ.push_back({c, a, b});
  endtask

  // done pulse; optionally drive an irq clear in the same cycle
  task automatic waitDone(input bit clearSame, input string tag);
    int n = 0;
    while (donePulse !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R1 done seen"}, 32'(donePulse), 32'd1);
    if (clearSame) begin
      hostWr = 1'b1; hostAddr = 3'd6; hostWData = 32'd1;
    end
    @(negedge clk);
    hostWr = 1'b0; hostWData = '0;
    chk({tag, " R1 pulse one cycle"}, 32'(donePulse), 32'd0);
    chk({tag, " R1 GO cleared"}, 32'(cmdWord[31]), 32'd0);
    chk({tag, " R10 irq set"}, 32'(doneIrq), 32'd1);
    chk({tag, " R6 all bus cycles seen"}, expQ.size(), 0);
    chk({tag, " R8 ce released"}, 32'(ceN), 32'hFF);
  endtask

  // monitor: scoreboard compare on every write strobe rise
  always @(negedge clk) begin
    if (rstN) begin
      if (!weN) weLow++;
      if (weN && !prevWe) begin
        chk("R12 strobe low width", weLow, 2);
        weLow = 0;
        if (expQ.size() == 0) chk("R6 unexpected bus cycle", {22'd0, cle, ale, ioOut}, 32'h3FF);
        else chk("R2/R3/R4 bus cycle", {22'd0, cle, ale, ioOut}, {22'd0, expQ.pop_front()});
      end
      if (!weN && prevWe) chk("R8 ce during write", 32'(ceN), 32'(expCe));
      if (!reN && prevRe) begin
        rdCount++;
        chk("R8 ce during read", 32'(ceN), 32'(expCe));
        ioIn = (rxQ.size() > 0) ? rxQ.pop_front() : 8'h00;
      end
      if (!weN && !reN) chk("R12 strobes exclusive", 32'd1, 32'd0);
      prevWe = weN;
      prevRe = reN;
    end
  end

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int startRd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset cmdWord", cmdWord, 32'd0);
    chk("R8 reset ce", 32'(ceN), 32'hFF);
    chk("R12 reset strobes", {30'd0, weN, reN}, 32'd3);
    chk("R10 reset irq", 32'(doneIrq), 32'd0);
    chk("R5 reset resp", respData, 32'd0);

    // T1: id-style read, one address cycle, four bytes in
    hostWrite(3'd1, 32'h90);
    hostWrite(3'd3, 32'h0);
    rxQ = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    expCe = 8'hFB;
    pushExp(1, 0, 8'h90); pushExp(0, 1, 8'h00);
    hostWrite(3'd0, 32'hF430_0400);
    waitDone(0, "T1");
    chk("R5 read bytes lanes", respData, 32'hDDCC_BBAA);

    // T2: page-read style with ready wait, response zeroed first
    hostWrite(3'd5, 32'hFFFF_FFFF);
    hostWrite(3'd1, 32'h00);
    hostWrite(3'd2, 32'h30);
    hostWrite(3'd3, 32'h4433_2211);
    hostWrite(3'd4, 32'h0000_0055);
    rbReady = 1'b0;
    rxQ = '{8'hB1, 8'hB2};
    expCe = 8'hFE;
    pushExp(1, 0, 8'h00);
    pushExp(0, 1, 8'h11); pushExp(0, 1, 8'h22); pushExp(0, 1, 8'h33);
    pushExp(0, 1, 8'h44); pushExp(0, 1, 8'h55);
    pushExp(1, 0, 8'h30);
    startRd = rdCount;
    hostWrite(3'd0, 32'hF611_0104);
    while (expQ.size() != 0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R7 no read while busy", rdCount - startRd, 0);
    chk("R7 ce held in wait", 32'(ceN), 32'hFE);
    rbReady = 1'b1;
    waitDone(0, "T2");
    chk("R5 zeroed and captured", respData, 32'h0000_B2B1);
    chk("R7 reads after ready", rdCount - startRd, 2);

    // T3: program with deferred second command
    hostWrite(3'd1, 32'h80);
    hostWrite(3'd2, 32'h10);
    hostWrite(3'd3, 32'h0000_0A0B);
    hostWrite(3'd5, 32'hDDCC_BBAA);
    expCe = 8'h7F;
    pushExp(1, 0, 8'h80); pushExp(0, 1, 8'h0B); pushExp(0, 1, 8'h0A);
    pushExp(0, 0, 8'hAA); pushExp(0, 0, 8'hBB); pushExp(0, 0, 8'hCC); pushExp(0, 0, 8'hDD);
    pushExp(1, 0, 8'h10);
    hostWrite(3'd0, 32'hFB30_8001);
    waitDone(0, "T3");

    // T4: data only, size clamped to 4, tx wins over rx
    hostWrite(3'd5, 32'h0403_0201);
    expCe = 8'hFD;
    startRd = rdCount;
    pushExp(0, 0, 8'h01); pushExp(0, 0, 8'h02); pushExp(0, 0, 8'h03); pushExp(0, 0, 8'h04);
    hostWrite(3'd0, 32'h9C90_0200);
    waitDone(0, "T4");
    chk("R5 tx precedence no read", rdCount - startRd, 0);
    chk("R4 resp kept on tx", respData, 32'h0403_0201);

    // T5: ten address cycles, no command
    hostWrite(3'd3, 32'h1312_1110);
    hostWrite(3'd4, 32'h1716_1514);
    expCe = 8'hF7;
    for (int k = 0; k < 8; k++) pushExp(0, 1, 8'(8'h10 + k));
    pushExp(0, 1, 8'h00); pushExp(0, 1, 8'h00);
    hostWrite(3'd0, 32'hA000_0809);
    waitDone(0, "T5");

    // T6: sticky irq and write-one clear
    repeat (5) @(negedge clk);
    chk("R10 irq sticky", 32'(doneIrq), 32'd1);
    hostWrite(3'd6, 32'd0);
    chk("R10 write zero keeps", 32'(doneIrq), 32'd1);
    hostWrite(3'd6, 32'd1);
    chk("R10 clear", 32'(doneIrq), 32'd0);

    // T7: abort during ready wait
    hostWrite(3'd1, 32'h70);
    rbReady = 1'b0;
    expCe = 8'hEF;
    pushExp(1, 0, 8'h70);
    hostWrite(3'd0, 32'hC001_1000);
    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R7 still selected in wait", 32'(ceN), 32'hEF);
    hostWrite(3'd0, 32'd0);
    chk("R9 ce released", 32'(ceN), 32'hFF);
    chk("R9 word cleared", cmdWord, 32'd0);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (donePulse) seen++;
      end
      chk("R9 no done after abort", seen, 0);
    end
    chk("R9 no irq after abort", 32'(doneIrq), 32'd0);
    rbReady = 1'b1;

    // T8: busy write ignored, then irq clear colliding with done
    hostWrite(3'd1, 32'h05);
    hostWrite(3'd3, 32'hA4A3_A2A1);
    expCe = 8'hDF;
    pushExp(1, 0, 8'h05);
    pushExp(0, 1, 8'hA1); pushExp(0, 1, 8'hA2); pushExp(0, 1, 8'hA3); pushExp(0, 1, 8'hA4);
    hostWrite(3'd0, 32'hE000_2003);
    repeat (3) @(negedge clk);
    hostWrite(3'd0, 32'hC000_0000);
    chk("R11 busy write ignored", cmdWord, 32'hE000_2003);
    waitDone(1, "T8 R10 set wins");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule